// File: doc/BRIEF.md
# Timed Test-Vector Apply and Compare Engine

This block plays a stored list of test vectors into a device under test and judges its responses. Each vector word carries the values to drive onto the device inputs, a three-valued expectation for every device output (high, low or not compared), an instruction and an optional timing-set selector. For every vector play the engine runs one test period, counted in base-clock ticks. It drives the inputs at tick 0, raises and lowers a device clock at programmed ticks, and compares the device outputs with the expectation at a programmed strobe tick.

Timing sets live in a small table loaded through a write port before a run. Each set holds a period length, a strobe tick and the device-clock rise and fall ticks. A write that would place the strobe at or past the end of the period, or break the rise/fall/strobe ordering, is refused and flagged. A vector that names a set switches to it, and the choice stays in force for later vectors. A repeat instruction replays one stored vector many times, so the same pattern can be rerun at shorter periods or shifted through a long scan chain without storing copies.

After a run, a sticky overall fail flag, a sticky per-pin fail mask, a count of failing plays and the address of the first failing vector stay readable until the next start.

Top module: `tvec_engine`

## Requirements
- R1: After synchronous active-low reset, busy, done, dut_clk, cmp_strobe, fail, ts_wr_err and first_fail_valid are 0; dut_in, pin_fail, fail_count and first_fail_addr are 0; every timing set holds period 16, strobe 12, rise 2, fall 6.
- R2: A start pulse while idle clears all results, selects timing set 0 and begins at vector address 0; start while busy has no effect. Vector word fields, LSB first: drive [3:0], expected level [7:4] (1 = high, 0 = low), compare mask [11:8] (0 = not compared), set-select flag [12], set index [14:13], instruction [16:15], repeat count [26:17].
- R3: dut_in takes the vector's drive bits at tick 0 of its first play and holds them through all its plays.
- R4: dut_clk is high exactly on ticks t with rise <= t < fall of the active timing set, and low whenever no vector is playing.
- R5: cmp_strobe is high on the strobe tick of every play; at that tick a pin mismatches only if its mask bit is 1 and dut_out differs from the expected level; masked pins never fail.
- R6: Any mismatch sets fail and ORs the mismatching pins into pin_fail; fail_count rises by one per play with a mismatch; first_fail_addr holds the address of the first failing play and first_fail_valid goes high with it; all hold until the next start.
- R7: A vector with the set-select flag loads the named timing set; a vector without it keeps the set in force, including across repeats; every run starts on set 0.
- R8: Instruction 1 plays the vector count times (count 0 or 1 means once); instructions 0 and 3 play once; instruction 2 plays once and ends the run; the run also ends after the vector at the last address.
- R9: done is a one-cycle pulse on the cycle after the last tick of the final play, and busy is low from that cycle on.
- R10: A timing-set write is accepted only if rise < fall <= strobe < period; otherwise the table is unchanged and ts_wr_err is high for the one cycle after the write.
- R11: Each play lasts exactly period cycles; replays follow back to back, and each new vector adds two fetch cycles, so a run lasts the sum over vectors of 2 + plays x period cycles from the start edge to done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run from address 0 |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at end of run |
| vec_we | input | 1 | Vector memory write enable |
| vec_waddr | input | AW | Vector memory write address |
| vec_wdata | input | VW | Vector word to store |
| ts_we | input | 1 | Timing-set write enable |
| ts_widx | input | TSW | Timing set to write |
| ts_period | input | TW | Period length in ticks |
| ts_strobe | input | TW | Compare tick |
| ts_rise | input | TW | Device clock rise tick |
| ts_fall | input | TW | Device clock fall tick |
| ts_wr_err | output | 1 | Last timing-set write was refused |
| dut_in | output | NIN | Drive values to device inputs |
| dut_clk | output | 1 | Device clock |
| dut_out | input | NOUT | Device outputs |
| cmp_strobe | output | 1 | Compare tick marker |
| fail | output | 1 | Sticky run fail flag |
| pin_fail | output | NOUT | Sticky per-pin fail mask |
| fail_count | output | FCW | Number of failing plays |
| first_fail_addr | output | AW | Address of first failing vector |
| first_fail_valid | output | 1 | first_fail_addr holds a failure |

## Verification
The assertions watch, on every cycle, that done is a single cycle and never coincides with busy, that the strobe never falls while the device clock is high, that the tick count stays below the active period, that every stored timing set keeps its ordering, and that the fail flag, pin mask, first-fail address and failure count only grow between starts. Only the bench's scenarios can show run lengths built from repeat counts and fetch gaps, the persistence of a timing set across vectors and its return to set 0 at start, the masking of uncompared pins, the ending on the stop instruction or the last address, and that start during a run and refused table writes leave the outcome untouched; a behavioural model in the bench predicts every output on every clock.

// File: rtl/tvec_pkg.sv
// Shared encodings for the test-vector engine.
// Assumes: vector instruction field is two bits wide.
package tvec_pkg;
    typedef enum logic [1:0] {
        OP_NOP  = 2'd0,
        OP_RPT  = 2'd1,
        OP_STOP = 2'd2,
        OP_SPR  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOAD,
        ST_RUN
    } st_e;
endpackage

// File: rtl/tvec_ram.sv
// Single-port-write, single-port-read synchronous vector store.
// Assumes: read data appears one cycle after the read address; no reset on contents.
module tvec_ram #(
    parameter int AW = 4,
    parameter int VW = 27
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [VW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [VW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [VW-1:0] mem [DEPTH];

    // Store a word on write and register the read word.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/tvec_tset.sv
// Timing-set table: period, strobe, clock rise and fall per set.
// Assumes: writes are checked for rise < fall <= strobe < period;
// refused writes leave the table alone and raise a one-cycle error.
module tvec_tset #(
    parameter int NTS      = 4,
    parameter int TSW      = 2,
    parameter int TW       = 8,
    parameter int DEF_PER  = 16,
    parameter int DEF_STB  = 12,
    parameter int DEF_RISE = 2,
    parameter int DEF_FALL = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [TSW-1:0] widx,
    input  logic [TW-1:0]  wper,
    input  logic [TW-1:0]  wstb,
    input  logic [TW-1:0]  wrise,
    input  logic [TW-1:0]  wfall,
    output logic           wr_err,
    input  logic [TSW-1:0] rsel,
    output logic [TW-1:0]  rper,
    output logic [TW-1:0]  rstb,
    output logic [TW-1:0]  rrise,
    output logic [TW-1:0]  rfall
);
    logic [TW-1:0] per_q  [NTS];
    logic [TW-1:0] stb_q  [NTS];
    logic [TW-1:0] rise_q [NTS];
    logic [TW-1:0] fall_q [NTS];
    logic          legal;

    // Ordering rule a new set must obey.
    assign legal = (wrise < wfall) && (wfall <= wstb) && (wstb < wper);

    // Load defaults on reset, then accept only legal writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NTS; i++) begin
                per_q[i]  <= TW'(DEF_PER);
                stb_q[i]  <= TW'(DEF_STB);
                rise_q[i] <= TW'(DEF_RISE);
                fall_q[i] <= TW'(DEF_FALL);
            end
            wr_err <= 1'b0;
        end else begin
            wr_err <= we && !legal;
            for (int i = 0; i < NTS; i++) begin
                if (we && legal && (widx == TSW'(i))) begin
                    per_q[i]  <= wper;
                    stb_q[i]  <= wstb;
                    rise_q[i] <= wrise;
                    fall_q[i] <= wfall;
                end
            end
        end
    end

    assign rper  = per_q[rsel];
    assign rstb  = stb_q[rsel];
    assign rrise = rise_q[rsel];
    assign rfall = fall_q[rsel];

    for (genvar g = 0; g < NTS; g++) begin : g_chk
        // R10
        tset_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rise_q[g] < fall_q[g]) && (fall_q[g] <= stb_q[g]) && (stb_q[g] < per_q[g]));
        // R10
        tset_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_err |-> (per_q[g] == $past(per_q[g]) && stb_q[g] == $past(stb_q[g])));
    end
endmodule

// File: rtl/tvec_seq.sv
// Playback sequencer: fetches vectors, counts ticks, drives inputs and
// device clock, marks the strobe tick, handles repeats and run end.
// Assumes: timing sets are legal; vector read latency is one cycle.
module tvec_seq
    import tvec_pkg::*;
#(
    parameter int NIN  = 4,
    parameter int NOUT = 4,
    parameter int AW   = 4,
    parameter int TSW  = 2,
    parameter int TW   = 8,
    parameter int CW   = 10,
    parameter int VW   = 27
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic [AW-1:0]   raddr,
    input  logic [VW-1:0]   vword,
    output logic [TSW-1:0]  tsel,
    input  logic [TW-1:0]   tper,
    input  logic [TW-1:0]   tstb,
    input  logic [TW-1:0]   trise,
    input  logic [TW-1:0]   tfall,
    output logic [NIN-1:0]  dut_in,
    output logic            dut_clk,
    output logic            strobe,
    output logic [NOUT-1:0] exp_lvl,
    output logic [NOUT-1:0] exp_care,
    output logic [AW-1:0]   cur_addr,
    output logic            clr,
    output logic            busy,
    output logic            done
);
    localparam int P_DRV  = 0;
    localparam int P_EXP  = NIN;
    localparam int P_CARE = NIN + NOUT;
    localparam int P_SET  = NIN + 2 * NOUT;
    localparam int P_IDX  = P_SET + 1;
    localparam int P_OP   = P_IDX + TSW;
    localparam int P_CNT  = P_OP + 2;
    localparam logic [AW-1:0] LAST = '1;

    st_e            st;
    logic [AW-1:0]  addr;
    logic [TW-1:0]  tick;
    logic [CW-1:0]  left;
    logic [TSW-1:0] cur_ts;
    logic [TW-1:0]  per, stb, rise, fall;
    op_e            op;
    logic           q_set;
    logic [TSW-1:0] q_idx;
    op_e            q_op;
    logic [CW-1:0]  q_cnt;
    logic           last_tick;

    // Field split of the fetched vector word.
    assign q_set = vword[P_SET];
    assign q_idx = vword[P_IDX +: TSW];
    assign q_op  = op_e'(vword[P_OP +: 2]);
    assign q_cnt = vword[P_CNT +: CW];

    assign raddr     = addr;
    assign tsel      = q_set ? q_idx : cur_ts;
    assign last_tick = (tick == per - TW'(1));

    // Playback state machine with tick and repeat counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            addr     <= '0;
            tick     <= '0;
            left     <= '0;
            cur_ts   <= '0;
            per      <= '0;
            stb      <= '0;
            rise     <= '0;
            fall     <= '0;
            op       <= OP_NOP;
            dut_in   <= '0;
            exp_lvl  <= '0;
            exp_care <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    addr   <= '0;
                    cur_ts <= '0;
                    st     <= ST_FETCH;
                end
                ST_FETCH: st <= ST_LOAD;
                ST_LOAD: begin
                    cur_ts   <= tsel;
                    per      <= tper;
                    stb      <= tstb;
                    rise     <= trise;
                    fall     <= tfall;
                    op       <= q_op;
                    dut_in   <= vword[P_DRV +: NIN];
                    exp_lvl  <= vword[P_EXP +: NOUT];
                    exp_care <= vword[P_CARE +: NOUT];
                    left     <= (q_op == OP_RPT && q_cnt > CW'(1)) ? q_cnt - CW'(1) : '0;
                    tick     <= '0;
                    st       <= ST_RUN;
                end
                default: begin
                    if (last_tick) begin
                        tick <= '0;
                        if (left != '0) begin
                            left <= left - CW'(1);
                        end else if (op == OP_STOP || addr == LAST) begin
                            st   <= ST_IDLE;
                            done <= 1'b1;
                        end else begin
                            addr <= addr + AW'(1);
                            st   <= ST_FETCH;
                        end
                    end else begin
                        tick <= tick + TW'(1);
                    end
                end
            endcase
        end
    end

    assign busy     = (st != ST_IDLE);
    assign clr      = start && (st == ST_IDLE);
    assign dut_clk  = (st == ST_RUN) && (tick >= rise) && (tick < fall);
    assign strobe   = (st == ST_RUN) && (tick == stb);
    assign cur_addr = addr;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R4
    clk_low_at_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> !dut_clk);
    // R11
    tick_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN) |-> (tick < per));
    // R3
    drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && $past(st) == ST_RUN) |-> $stable(dut_in));
endmodule

// File: rtl/tvec_cmp.sv
// Strobe comparator and result accumulator.
// Assumes: strobe is high for one cycle per play; clr arrives with start.
module tvec_cmp #(
    parameter int NOUT = 4,
    parameter int AW   = 4,
    parameter int FCW  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            strobe,
    input  logic [NOUT-1:0] dut_out,
    input  logic [NOUT-1:0] exp_lvl,
    input  logic [NOUT-1:0] exp_care,
    input  logic [AW-1:0]   addr,
    output logic            fail,
    output logic [NOUT-1:0] pin_fail,
    output logic [FCW-1:0]  fail_count,
    output logic [AW-1:0]   first_addr,
    output logic            first_valid
);
    logic [NOUT-1:0] mism;
    logic            hit;

    // Mismatch only on compared pins, only at the strobe tick.
    assign mism = exp_care & (dut_out ^ exp_lvl);
    assign hit  = strobe && (|mism);

    // Accumulate sticky results until the next start.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            fail        <= 1'b0;
            pin_fail    <= '0;
            fail_count  <= '0;
            first_addr  <= '0;
            first_valid <= 1'b0;
        end else if (hit) begin
            fail     <= 1'b1;
            pin_fail <= pin_fail | mism;
            if (fail_count != '1) fail_count <= fail_count + FCW'(1);
            if (!first_valid) begin
                first_valid <= 1'b1;
                first_addr  <= addr;
            end
        end
    end

    // R6
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !clr) |=> fail);
    // R6
    first_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (first_valid && !clr) |=> $stable(first_addr));
    // R6
    count_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (fail_count >= $past(fail_count)));
    // R5
    pin_mask_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (($past(pin_fail) & ~pin_fail) == '0));
endmodule

// File: rtl/tvec_engine.sv
// Top of the timed test-vector apply and compare engine.
// Assumes: vector memory and timing sets are written while idle.
module tvec_engine #(
    parameter int NIN      = 4,
    parameter int NOUT     = 4,
    parameter int AW       = 4,
    parameter int NTS      = 4,
    parameter int TW       = 8,
    parameter int CW       = 10,
    parameter int FCW      = 16,
    parameter int DEF_PER  = 16,
    parameter int DEF_STB  = 12,
    parameter int DEF_RISE = 2,
    parameter int DEF_FALL = 6,
    localparam int TSW     = $clog2(NTS),
    localparam int VW      = NIN + 2 * NOUT + 1 + TSW + 2 + CW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic            busy,
    output logic            done,
    input  logic            vec_we,
    input  logic [AW-1:0]   vec_waddr,
    input  logic [VW-1:0]   vec_wdata,
    input  logic            ts_we,
    input  logic [TSW-1:0]  ts_widx,
    input  logic [TW-1:0]   ts_period,
    input  logic [TW-1:0]   ts_strobe,
    input  logic [TW-1:0]   ts_rise,
    input  logic [TW-1:0]   ts_fall,
    output logic            ts_wr_err,
    output logic [NIN-1:0]  dut_in,
    output logic            dut_clk,
    input  logic [NOUT-1:0] dut_out,
    output logic            cmp_strobe,
    output logic            fail,
    output logic [NOUT-1:0] pin_fail,
    output logic [FCW-1:0]  fail_count,
    output logic [AW-1:0]   first_fail_addr,
    output logic            first_fail_valid
);
    logic [AW-1:0]   raddr, cur_addr;
    logic [VW-1:0]   vword;
    logic [TSW-1:0]  tsel;
    logic [TW-1:0]   tper, tstb, trise, tfall;
    logic [NOUT-1:0] exp_lvl, exp_care;
    logic            clr;

    tvec_ram #(.AW(AW), .VW(VW)) u_ram (
        .clk(clk), .we(vec_we), .waddr(vec_waddr), .wdata(vec_wdata),
        .raddr(raddr), .rdata(vword)
    );

    tvec_tset #(
        .NTS(NTS), .TSW(TSW), .TW(TW), .DEF_PER(DEF_PER), .DEF_STB(DEF_STB),
        .DEF_RISE(DEF_RISE), .DEF_FALL(DEF_FALL)
    ) u_tset (
        .clk(clk), .rst_n(rst_n), .we(ts_we), .widx(ts_widx), .wper(ts_period),
        .wstb(ts_strobe), .wrise(ts_rise), .wfall(ts_fall), .wr_err(ts_wr_err),
        .rsel(tsel), .rper(tper), .rstb(tstb), .rrise(trise), .rfall(tfall)
    );

    tvec_seq #(
        .NIN(NIN), .NOUT(NOUT), .AW(AW), .TSW(TSW), .TW(TW), .CW(CW), .VW(VW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .raddr(raddr), .vword(vword),
        .tsel(tsel), .tper(tper), .tstb(tstb), .trise(trise), .tfall(tfall),
        .dut_in(dut_in), .dut_clk(dut_clk), .strobe(cmp_strobe),
        .exp_lvl(exp_lvl), .exp_care(exp_care), .cur_addr(cur_addr),
        .clr(clr), .busy(busy), .done(done)
    );

    tvec_cmp #(.NOUT(NOUT), .AW(AW), .FCW(FCW)) u_cmp (
        .clk(clk), .rst_n(rst_n), .clr(clr), .strobe(cmp_strobe),
        .dut_out(dut_out), .exp_lvl(exp_lvl), .exp_care(exp_care),
        .addr(cur_addr), .fail(fail), .pin_fail(pin_fail),
        .fail_count(fail_count), .first_addr(first_fail_addr),
        .first_valid(first_fail_valid)
    );
endmodule

// File: tb/tvec_engine_bench.sv
// Bench: behavioural reference model compared on every clock plus scenario checks.
module tvec_engine_bench;
    localparam int NIN = 4, NOUT = 4, AW = 4, TW = 8, FCW = 16, VW = 27;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, start, busy, done, vec_we, ts_we, ts_wr_err, dut_clk, cmp_strobe;
    logic fail, first_fail_valid;
    logic [AW-1:0]   vec_waddr, first_fail_addr;
    logic [VW-1:0]   vec_wdata;
    logic [1:0]      ts_widx;
    logic [TW-1:0]   ts_period, ts_strobe, ts_rise, ts_fall;
    logic [NIN-1:0]  dut_in;
    logic [NOUT-1:0] dut_out, pin_fail, flip;
    logic [FCW-1:0]  fail_count;

    assign dut_out = dut_in ^ flip;

    tvec_engine u_tvec_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .vec_we(vec_we), .vec_waddr(vec_waddr), .vec_wdata(vec_wdata),
        .ts_we(ts_we), .ts_widx(ts_widx), .ts_period(ts_period),
        .ts_strobe(ts_strobe), .ts_rise(ts_rise), .ts_fall(ts_fall),
        .ts_wr_err(ts_wr_err), .dut_in(dut_in), .dut_clk(dut_clk),
        .dut_out(dut_out), .cmp_strobe(cmp_strobe), .fail(fail),
        .pin_fail(pin_fail), .fail_count(fail_count),
        .first_fail_addr(first_fail_addr), .first_fail_valid(first_fail_valid)
    );

    int n_chk = 0, n_fail = 0;
    logic cmp_en = 1'b0;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [VW-1:0] mmem [16];
    int sp [4], ss [4], sr [4], sf [4];
    int ph, m_addr, tk, left, m_ts, m_op, m_cnt, t_per, t_stb, t_rise, t_fall;
    logic [3:0] m_exp, m_care, mism, w_drv;
    logic [VW-1:0] w;
    logic e_busy, e_done, e_clk, e_stb, e_fail, e_err, e_ffv;
    logic [3:0] e_din, e_pin, e_ffa;
    int e_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin sp[i] = 16; ss[i] = 12; sr[i] = 2; sf[i] = 6; end
            ph = 0; m_addr = 0; tk = 0; left = 0; m_ts = 0; m_op = 0;
            t_per = 0; t_stb = 0; t_rise = 0; t_fall = 0;
            m_exp = 0; m_care = 0; e_din = 0; e_pin = 0; e_ffa = 0;
            e_busy = 0; e_done = 0; e_clk = 0; e_stb = 0; e_fail = 0; e_err = 0; e_ffv = 0; e_cnt = 0;
        end else begin
            e_done = 0;
            e_err = 0;
            if (ph == 3 && tk == t_stb) begin
                mism = m_care & (dut_out ^ m_exp);
                if (mism != 0) begin
                    e_fail = 1; e_pin = e_pin | mism;
                    if (e_cnt < 65535) e_cnt++;
                    if (!e_ffv) begin e_ffv = 1; e_ffa = 4'(m_addr); end
                end
            end
            if (ph == 0) begin
                if (start) begin
                    e_fail = 0; e_pin = 0; e_cnt = 0; e_ffv = 0; e_ffa = 0;
                    m_addr = 0; m_ts = 0; ph = 1;
                end
            end else if (ph == 1) begin
                ph = 2;
            end else if (ph == 2) begin
                w = mmem[m_addr];
                if (w[12]) m_ts = int'(w[14:13]);
                t_per = sp[m_ts]; t_stb = ss[m_ts]; t_rise = sr[m_ts]; t_fall = sf[m_ts];
                w_drv = w[3:0]; e_din = w_drv; m_exp = w[7:4]; m_care = w[11:8];
                m_op = int'(w[16:15]); m_cnt = int'(w[26:17]);
                left = (m_op == 1 && m_cnt > 1) ? m_cnt - 1 : 0;
                tk = 0; ph = 3;
            end else begin
                if (tk == t_per - 1) begin
                    if (left > 0) begin left--; tk = 0; end
                    else if (m_op == 2 || m_addr == 15) begin ph = 0; e_done = 1; end
                    else begin m_addr++; ph = 1; end
                end else tk++;
            end
            if (ts_we) begin
                if (ts_rise < ts_fall && ts_fall <= ts_strobe && ts_strobe < ts_period) begin
                    sp[ts_widx] = int'(ts_period); ss[ts_widx] = int'(ts_strobe);
                    sr[ts_widx] = int'(ts_rise);   sf[ts_widx] = int'(ts_fall);
                end else e_err = 1;
            end
            if (vec_we) mmem[vec_waddr] = vec_wdata;
            e_busy = (ph != 0);
            e_clk  = (ph == 3) && (tk >= t_rise) && (tk < t_fall);
            e_stb  = (ph == 3) && (tk == t_stb);
        end
    end

    // Compare every output against the model once per clock.
    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R9", "busy", 32'(busy), 32'(e_busy));
            chk("R9", "done", 32'(done), 32'(e_done));
            chk("R3", "dut_in", 32'(dut_in), 32'(e_din));
            chk("R4", "dut_clk", 32'(dut_clk), 32'(e_clk));
            chk("R5", "cmp_strobe", 32'(cmp_strobe), 32'(e_stb));
            chk("R6", "fail", 32'(fail), 32'(e_fail));
            chk("R5", "pin_fail", 32'(pin_fail), 32'(e_pin));
            chk("R6", "fail_count", 32'(fail_count), 32'(e_cnt));
            chk("R6", "first_fail", {27'd0, first_fail_valid, first_fail_addr}, {27'd0, e_ffv, e_ffa});
            chk("R10", "ts_wr_err", 32'(ts_wr_err), 32'(e_err));
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [VW-1:0] mkv(input logic [3:0] drv, input logic [3:0] ex,
        input logic [3:0] care, input logic sel, input logic [1:0] idx,
        input logic [1:0] op, input logic [9:0] cnt);
        return {cnt, op, idx, sel, care, ex, drv};
    endfunction

    task automatic wr_vec(input int a, input logic [VW-1:0] d);
        @(negedge clk); vec_we = 1; vec_waddr = 4'(a); vec_wdata = d;
        @(negedge clk); vec_we = 0;
    endtask

    task automatic wr_ts(input int i, input int p, input int s, input int r, input int f);
        @(negedge clk); ts_we = 1; ts_widx = 2'(i);
        ts_period = 8'(p); ts_strobe = 8'(s); ts_rise = 8'(r); ts_fall = 8'(f);
        @(negedge clk); ts_we = 0;
        chk("R10", "write refusal flag", 32'(ts_wr_err), 32'(!(r < f && f <= s && s < p)));
    endtask

    // Start a run, optionally pulse start again mid-run, return cycles to done.
    task automatic run(input int restart_at, output int cyc);
        @(negedge clk); start = 1;
        @(negedge clk); start = 0; cyc = 1;
        while (!done && cyc < 5000) begin
            start = (cyc == restart_at);
            @(negedge clk); cyc++;
        end
        start = 0;
    endtask

    localparam logic [1:0] NOP = 2'd0, RPT = 2'd1, STP = 2'd2;

    initial begin
        int cyc;
        rst_n = 0; start = 0; vec_we = 0; ts_we = 0; vec_waddr = 0; vec_wdata = 0;
        ts_widx = 0; ts_period = 0; ts_strobe = 0; ts_rise = 0; ts_fall = 0; flip = 0;
        repeat (2) @(negedge clk);
        cmp_en = 1;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy", 32'(busy), 0);
        chk("R1", "dut_in", 32'(dut_in), 0);
        chk("R1", "dut_clk", 32'(dut_clk), 0);
        chk("R1", "fail", 32'(fail), 0);
        chk("R1", "fail_count", 32'(fail_count), 0);
        chk("R1", "first_fail_valid", 32'(first_fail_valid), 0);

        // Timing sets, then refused writes that must leave set 2 and 1 intact (R10)
        wr_ts(0, 12, 9, 2, 5);
        wr_ts(1, 10, 8, 2, 4);
        wr_ts(2, 8, 6, 1, 3);
        wr_ts(3, 6, 5, 1, 2);
        wr_ts(2, 8, 8, 1, 3);
        wr_ts(2, 9, 5, 1, 6);
        wr_ts(1, 10, 8, 4, 4);

        // Program A: expected levels mirror drive; v3 leaves pin 3 uncompared
        wr_vec(0, mkv(4'b0101, 4'b0101, 4'hF, 1, 0, NOP, 0));
        wr_vec(1, mkv(4'b0011, 4'b0011, 4'hF, 1, 1, RPT, 3));
        wr_vec(2, mkv(4'b1100, 4'b1100, 4'hF, 0, 0, NOP, 0));
        wr_vec(3, mkv(4'b1010, 4'b1010, 4'b0111, 0, 0, NOP, 0));
        wr_vec(4, mkv(4'b1111, 4'b1111, 4'hF, 1, 2, STP, 0));
        for (int i = 5; i < 16; i++) wr_vec(i, mkv(4'(i), 4'(i), 4'hF, 0, 0, NOP, 0));

        // R11 R7 R10: 14 + 32 + 12 + 12 + 10 cycles, refused writes did not alter sets
        run(0, cyc);
        chk("R11", "run length program A", 32'(cyc), 32'(81));
        chk("R6", "clean device no fail", 32'(fail), 0);

        // R2: start during run ignored; pin 3 stuck wrong
        flip = 4'b1000;
        run(10, cyc);
        chk("R2", "run length with mid-run start", 32'(cyc), 32'(81));
        chk("R6", "failing plays", 32'(fail_count), 32'(6));
        chk("R5", "pin mask", 32'(pin_fail), 32'(4'b1000));
        chk("R6", "first fail addr", {first_fail_valid, first_fail_addr}, {1'b1, 4'd0});

        // R5: mask pin 3 on v0 too, first failure moves to address 1
        wr_vec(0, mkv(4'b0101, 4'b0101, 4'b0111, 1, 0, NOP, 0));
        run(0, cyc);
        chk("R5", "masked pin not counted", 32'(fail_count), 32'(5));
        chk("R6", "first fail addr", {first_fail_valid, first_fail_addr}, {1'b1, 4'd1});

        // R8: no stop, run ends after address 15; all on set 3 (period 6)
        flip = 4'b0000;
        for (int i = 0; i < 16; i++) wr_vec(i, mkv(4'(i), 4'(i), 4'hF, 1, 3, NOP, 0));
        run(0, cyc);
        chk("R8", "end at last address", 32'(cyc), 32'(129));
        chk("R2", "results cleared by start", {fail, first_fail_valid}, 0);

        // R7: run restarts on set 0 (period 12); R8 repeat count 0 plays once
        wr_vec(0, mkv(4'b0110, 4'b0110, 4'hF, 0, 0, NOP, 0));
        wr_vec(1, mkv(4'b1001, 4'b1001, 4'hF, 0, 0, RPT, 0));
        wr_vec(2, mkv(4'b0000, 4'b0000, 4'hF, 0, 0, STP, 0));
        run(0, cyc);
        chk("R7", "set 0 at start, count 0 once", 32'(cyc), 32'(43));

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R9 watchdog act=no_end exp=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule